// File: doc/BRIEF.md
# Processor Status Flag Register with Interrupt Masks

This block holds the eight-bit status byte of a small processor core. Each cycle it may take an arithmetic-unit result together with both operand bytes and an operation class, and from them it updates the negative, zero, half-carry, overflow and carry flags. Two of the bits are interrupt masks. One gates the ordinary maskable request. The other gates a high-priority request that stays masked from reset until software opens it.

The interrupt sequencer reports each step of an interrupt through strobes: entry (with the source kind), the end of register stacking, and the vector fetch. The block closes the matching masks at the end of stacking, so they are already closed when the vector is fetched. A restore strobe reloads the whole byte from the stacked copy. The high-priority mask cannot be reopened to one by software or by a restore. Two registered outputs tell the sequencer whether a pending request of each kind may be taken.

Top module: `status_flags_unit`

## Requirements
- R1: Reset is synchronous and active high. After reset, flags = 0xD0 (stop-disable 1, high-priority mask 1, low-priority mask 1, every other bit 0), and both accept outputs are 0.
- R2: Bit layout, bit 7 down to bit 0: stop-disable, high-priority mask (bit 6), half carry (bit 5), low-priority mask (bit 4), negative (bit 3), zero (bit 2), overflow (bit 1), carry (bit 0). The alu_op codes are 0 none, 1 add, 2 add-with-carry, 3 accumulator add, 4 logic, 5 move, and 6 and 7 are treated as none. For codes 1 to 5 with alu_valid high, negative takes bit 7 of alu_res and zero is set when alu_res is 0. Code 0, codes 6 and 7, and alu_valid low leave bits 3..0 unchanged.
- R3: For codes 1, 2 and 3, half carry is set when alu_a[3:0] + alu_b[3:0] + carry-in exceeds 15 and is cleared otherwise. Every other code keeps its previous value.
- R4: For codes 1, 2 and 3, carry is the ninth bit of alu_a + alu_b + carry-in. Overflow is set when both operands have the same bit 7 and the bit 7 of that sum differs from it. Carry-in is the current carry flag for code 2 and 0 otherwise. Codes 4 and 5 clear overflow and keep carry.
- R5: acc_lp is high one cycle after req_lp is high, and only if the updated low-priority mask is 0. While that mask is 1, a held request is not accepted.
- R6: acc_hp is high one cycle after req_hp is high, and only if the updated high-priority mask is 0.
- R7: After int_entry with int_entry_hp low, the stack_done strobe sets the low-priority mask and leaves the high-priority mask unchanged. The mask is 1 by the time vec_fetch arrives.
- R8: After int_entry with int_entry_hp high, stack_done sets both masks.
- R9: restore loads every bit from restore_data, except that the high-priority mask becomes restore_data[6] AND its current value. restore has priority over all other updates in the same cycle.
- R10: sw_clr_lp clears the low-priority mask and sw_set_lp sets it, with set winning when both are high. sw_clr_hp clears the high-priority mask. sw_set_hp never changes a 0 high-priority mask to 1, and when high together with sw_clr_hp it keeps a 1.
- R11: stack_done with no open entry has no effect. An entry is opened by int_entry only when no sequence is in progress, and vec_fetch ends the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | Result inputs are valid this cycle |
| alu_op | input | 3 | Operation class code |
| alu_a | input | 8 | First operand |
| alu_b | input | 8 | Second operand |
| alu_res | input | 8 | Result byte |
| sw_set_lp | input | 1 | Software set of low-priority mask |
| sw_clr_lp | input | 1 | Software clear of low-priority mask |
| sw_set_hp | input | 1 | Software set request for high-priority mask |
| sw_clr_hp | input | 1 | Software clear of high-priority mask |
| int_entry | input | 1 | Interrupt sequence begins |
| int_entry_hp | input | 1 | Entering source is the high-priority one |
| stack_done | input | 1 | Register stacking finished |
| vec_fetch | input | 1 | Vector fetch under way |
| restore | input | 1 | Reload flags from stacked copy |
| restore_data | input | 8 | Stacked flag byte |
| req_lp | input | 1 | Maskable request pending |
| req_hp | input | 1 | High-priority request pending |
| flags | output | 8 | Status flag byte |
| acc_lp | output | 1 | Maskable request may be taken |
| acc_hp | output | 1 | High-priority request may be taken |

## Verification
Every operand pair for the plain add and a dense grid for add-with-carry at both carry-in values are checked against sums computed in the bench. These catch a half carry taken from the wrong bit, or a carry-in that is ignored or used by the wrong class. Logic and move operations are run with half carry and carry set beforehand, which exposes a design that clears or recomputes flags these classes must keep. The interrupt sequences are run with the high-priority mask already open, so a design that sets the masks at entry or at vector fetch instead of after stacking, or that lets a low-priority entry close the high-priority mask, gives a wrong byte. Restores and software set strobes aimed at an open high-priority mask show whether it can be reopened to one illegally.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ADD    = 3'd1,
    OP_ADC    = 3'd2,
    OP_ADDACC = 3'd3,
    OP_LOGIC  = 3'd4,
    OP_MOVE   = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_OPEN    = 2'd1,
    SEQ_STACKED = 2'd2
  } seq_e;

  localparam int B_STOP  = 7;
  localparam int B_HMASK = 6;
  localparam int B_HALF  = 5;
  localparam int B_LMASK = 4;
  localparam int B_NEG   = 3;
  localparam int B_ZERO  = 2;
  localparam int B_OVF   = 1;
  localparam int B_CARRY = 0;

  localparam logic [7:0] FLAGS_RESET = 8'hD0;

  typedef struct packed {
    logic half;
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } arith_t;
endpackage

// File: rtl/sfu_arith_flags.sv
module sfu_arith_flags
  import sfu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          valid,
  input  op_class_e     op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] res,
  input  arith_t        cur,
  output arith_t        nxt
);
  localparam int HW = DW / 2;

  logic          is_add;
  logic          is_nz_only;
  logic          cin;
  logic [DW:0]   sum;
  logic [HW:0]   lo_sum;

  always_comb begin
    is_add     = valid && (op == OP_ADD || op == OP_ADC || op == OP_ADDACC);
    is_nz_only = valid && (op == OP_LOGIC || op == OP_MOVE);
    cin        = (op == OP_ADC) ? cur.carry : 1'b0;
    sum        = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    lo_sum     = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
  end

  always_comb begin
    nxt = cur;
    if (is_add) begin
      nxt.half  = lo_sum[HW];
      nxt.neg   = res[DW-1];
      nxt.zero  = (res == '0);
      nxt.ovf   = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
      nxt.carry = sum[DW];
    end else if (is_nz_only) begin
      nxt.neg   = res[DW-1];
      nxt.zero  = (res == '0);
      nxt.ovf   = 1'b0;
    end
  end
endmodule

// File: rtl/sfu_mask_ctrl.sv
module sfu_mask_ctrl
  import sfu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic int_entry,
  input  logic int_entry_hp,
  input  logic stack_done,
  input  logic vec_fetch,
  input  logic sw_set_lp,
  input  logic sw_clr_lp,
  input  logic sw_set_hp,
  input  logic sw_clr_hp,
  input  logic cur_lmask,
  input  logic cur_hmask,
  output logic nxt_lmask,
  output logic nxt_hmask,
  output logic seq_stacked
);
  seq_e seq_q;
  logic kind_hp_q;
  logic close_now;

  assign close_now   = (seq_q == SEQ_OPEN) && stack_done;
  assign seq_stacked = (seq_q == SEQ_STACKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q     <= SEQ_IDLE;
      kind_hp_q <= 1'b0;
    end else begin
      case (seq_q)
        SEQ_IDLE: if (int_entry) begin
          seq_q     <= SEQ_OPEN;
          kind_hp_q <= int_entry_hp;
        end
        SEQ_OPEN:    if (stack_done) seq_q <= SEQ_STACKED;
        SEQ_STACKED: if (vec_fetch)  seq_q <= SEQ_IDLE;
        default:     seq_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    nxt_lmask = cur_lmask;
    if (sw_clr_lp) nxt_lmask = 1'b0;
    if (sw_set_lp) nxt_lmask = 1'b1;
    if (close_now) nxt_lmask = 1'b1;

    // software may only lower this mask; a set strobe merely protects a 1
    nxt_hmask = cur_hmask & (sw_set_hp | ~sw_clr_hp);
    if (close_now && kind_hp_q) nxt_hmask = 1'b1;
  end
endmodule

// File: rtl/status_flags_unit.sv
module status_flags_unit
  import sfu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alu_valid,
  input  logic [2:0]    alu_op,
  input  logic [DW-1:0] alu_a,
  input  logic [DW-1:0] alu_b,
  input  logic [DW-1:0] alu_res,
  input  logic          sw_set_lp,
  input  logic          sw_clr_lp,
  input  logic          sw_set_hp,
  input  logic          sw_clr_hp,
  input  logic          int_entry,
  input  logic          int_entry_hp,
  input  logic          stack_done,
  input  logic          vec_fetch,
  input  logic          restore,
  input  logic [7:0]    restore_data,
  input  logic          req_lp,
  input  logic          req_hp,
  output logic [7:0]    flags,
  output logic          acc_lp,
  output logic          acc_hp
);
  logic [7:0] flags_q;
  logic [7:0] flags_d;
  arith_t     ar_cur;
  arith_t     ar_nxt;
  logic       lmask_n;
  logic       hmask_n;
  logic       seq_stacked;

  assign ar_cur = '{half:  flags_q[B_HALF],  neg: flags_q[B_NEG],
                    zero:  flags_q[B_ZERO],  ovf: flags_q[B_OVF],
                    carry: flags_q[B_CARRY]};

  sfu_arith_flags #(.DW(DW)) u_arith (
    .valid (alu_valid),
    .op    (op_class_e'(alu_op)),
    .a     (alu_a),
    .b     (alu_b),
    .res   (alu_res),
    .cur   (ar_cur),
    .nxt   (ar_nxt)
  );

  sfu_mask_ctrl u_mask (
    .clk          (clk),
    .rst          (rst),
    .int_entry    (int_entry),
    .int_entry_hp (int_entry_hp),
    .stack_done   (stack_done),
    .vec_fetch    (vec_fetch),
    .sw_set_lp    (sw_set_lp),
    .sw_clr_lp    (sw_clr_lp),
    .sw_set_hp    (sw_set_hp),
    .sw_clr_hp    (sw_clr_hp),
    .cur_lmask    (flags_q[B_LMASK]),
    .cur_hmask    (flags_q[B_HMASK]),
    .nxt_lmask    (lmask_n),
    .nxt_hmask    (hmask_n),
    .seq_stacked  (seq_stacked)
  );

  always_comb begin
    if (restore) begin
      flags_d          = restore_data;
      flags_d[B_HMASK] = restore_data[B_HMASK] & flags_q[B_HMASK];
    end else begin
      flags_d          = flags_q;
      flags_d[B_HMASK] = hmask_n;
      flags_d[B_LMASK] = lmask_n;
      flags_d[B_HALF]  = ar_nxt.half;
      flags_d[B_NEG]   = ar_nxt.neg;
      flags_d[B_ZERO]  = ar_nxt.zero;
      flags_d[B_OVF]   = ar_nxt.ovf;
      flags_d[B_CARRY] = ar_nxt.carry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= FLAGS_RESET;
      acc_lp  <= 1'b0;
      acc_hp  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      acc_lp  <= req_lp & ~flags_d[B_LMASK];
      acc_hp  <= req_hp & ~flags_d[B_HMASK];
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] flags,
  input logic       acc_lp,
  input logic       acc_hp,
  input logic       alu_valid,
  input logic       restore,
  input logic       stack_done,
  input logic       sw_clr_hp,
  input logic       vec_fetch,
  input logic       seq_stacked
);
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (flags == 8'hD0 && !acc_lp && !acc_hp));

  a_r2_idle_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (!alu_valid && !restore) |=> $stable(flags[3:0]));

  a_r5_lp_gated: assert property (@(posedge clk) disable iff (rst)
    acc_lp |-> !flags[4]);

  a_r6_hp_gated: assert property (@(posedge clk) disable iff (rst)
    acc_hp |-> !flags[6]);

  a_r7_masked_at_fetch: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch && seq_stacked) |-> flags[4]);

  a_r9_hp_no_reopen: assert property (@(posedge clk) disable iff (rst)
    (!flags[6] && !stack_done) |=> !flags[6]);

  a_r10_hp_clear: assert property (@(posedge clk) disable iff (rst)
    (sw_clr_hp && !restore && !stack_done && !seq_stacked) |=> !flags[6] || $past(flags[6]));
endmodule

bind status_flags_unit sfu_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .flags       (flags),
  .acc_lp      (acc_lp),
  .acc_hp      (acc_hp),
  .alu_valid   (alu_valid),
  .restore     (restore),
  .stack_done  (stack_done),
  .sw_clr_hp   (sw_clr_hp),
  .vec_fetch   (vec_fetch),
  .seq_stacked (seq_stacked)
);

// File: tb/status_flags_unit_bench.sv
module status_flags_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alu_valid = 0;
  logic [2:0] alu_op = 0;
  logic [7:0] alu_a = 0, alu_b = 0, alu_res = 0;
  logic       sw_set_lp = 0, sw_clr_lp = 0, sw_set_hp = 0, sw_clr_hp = 0;
  logic       int_entry = 0, int_entry_hp = 0, stack_done = 0, vec_fetch = 0;
  logic       restore = 0;
  logic [7:0] restore_data = 0;
  logic       req_lp = 0, req_hp = 0;
  logic [7:0] flags;
  logic       acc_lp, acc_hp;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_f;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flags_unit u_status_flags_unit (
    .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_op(alu_op),
    .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
    .sw_set_lp(sw_set_lp), .sw_clr_lp(sw_clr_lp),
    .sw_set_hp(sw_set_hp), .sw_clr_hp(sw_clr_hp),
    .int_entry(int_entry), .int_entry_hp(int_entry_hp),
    .stack_done(stack_done), .vec_fetch(vec_fetch),
    .restore(restore), .restore_data(restore_data),
    .req_lp(req_lp), .req_hp(req_hp),
    .flags(flags), .acc_lp(acc_lp), .acc_hp(acc_hp)
  );

  function automatic logic [7:0] model(input logic [7:0] f, input logic [2:0] op,
                                       input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] r);
    logic [7:0] o;
    int cin, s, lo;
    o   = f;
    cin = (op == 3'd2) ? int'(f[0]) : 0;
    s   = int'(a) + int'(b) + cin;
    lo  = int'(a % 16) + int'(b % 16) + cin;
    if (op == 3'd1 || op == 3'd2 || op == 3'd3) begin
      o[5] = (lo > 15);
      o[3] = r[7];
      o[2] = (r == 8'd0);
      o[1] = (a[7] == b[7]) && (((s / 128) % 2) != int'(a[7]));
      o[0] = (s > 255);
    end else if (op == 3'd4 || op == 3'd5) begin
      o[3] = r[7];
      o[2] = (r == 8'd0);
      o[1] = 1'b0;
    end
    return o;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    alu_valid = 0; alu_op = 0; sw_set_lp = 0; sw_clr_lp = 0; sw_set_hp = 0;
    sw_clr_hp = 0; int_entry = 0; int_entry_hp = 0; stack_done = 0;
    vec_fetch = 0; restore = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic alu_step(input logic [2:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] r, input string req);
    alu_valid = 1; alu_op = op; alu_a = a; alu_b = b; alu_res = r;
    exp_f = model(exp_f, op, a, b, r);
    tick();
    chk(req, int'(flags), int'(exp_f));
    clear_in();
  endtask

  task automatic do_restore(input logic [7:0] d);
    restore = 1; restore_data = d;
    tick();
    clear_in();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R1 flags", int'(flags), 'hD0);
    chk("R1 acc_lp", int'(acc_lp), 0);
    chk("R1 acc_hp", int'(acc_hp), 0);

    // R5: pending while masked, accepted after clear
    req_lp = 1; tick();
    chk("R5 masked", int'(acc_lp), 0);
    sw_clr_lp = 1; tick(); clear_in();
    chk("R10 clear lp", int'(flags), 'hC0);
    chk("R5 accepted", int'(acc_lp), 1);
    sw_set_lp = 1; sw_clr_lp = 1; tick(); clear_in();
    chk("R10 set wins", int'(flags), 'hD0);
    chk("R5 blocked again", int'(acc_lp), 0);
    sw_clr_lp = 1; tick(); clear_in(); req_lp = 0;

    // R11: stacking strobe with no open entry
    stack_done = 1; tick(); clear_in();
    chk("R11 stray stack_done", int'(flags), 'hC0);

    // R6 and R10 on high-priority mask
    req_hp = 1; tick();
    chk("R6 masked", int'(acc_hp), 0);
    sw_clr_hp = 1; tick(); clear_in();
    chk("R10 clear hp", int'(flags), 'h80);
    chk("R6 accepted", int'(acc_hp), 1);
    req_hp = 0;
    sw_set_hp = 1; tick(); clear_in();
    chk("R10 set hp ignored", int'(flags), 'h80);

    // R9: restore cannot reopen high-priority mask
    do_restore(8'hFF);
    chk("R9 restore keeps hp 0", int'(flags), 'hBF);
    do_restore(8'h80);
    chk("R9 restore byte", int'(flags), 'h80);

    // R7: low-priority sequence
    int_entry = 1; tick(); clear_in();
    chk("R7 no change at entry", int'(flags), 'h80);
    stack_done = 1; tick(); clear_in();
    chk("R7 lp mask after stacking", int'(flags), 'h90);
    vec_fetch = 1; tick(); clear_in();
    chk("R7 held through fetch", int'(flags), 'h90);
    do_restore(8'h80);
    chk("R9 return lp", int'(flags), 'h80);

    // R8: high-priority sequence
    int_entry = 1; int_entry_hp = 1; tick(); clear_in();
    chk("R8 no change at entry", int'(flags), 'h80);
    stack_done = 1; tick(); clear_in();
    chk("R8 both masks", int'(flags), 'hD0);
    vec_fetch = 1; tick(); clear_in();
    do_restore(8'h80);
    chk("R9 return hp", int'(flags), 'h80);

    // R2: non-updating codes
    exp_f = 8'h80;
    alu_step(3'd1, 8'hFF, 8'hFF, 8'hFE, "R4 setup");
    alu_step(3'd0, 8'h00, 8'h00, 8'h00, "R2 code0 none");
    alu_step(3'd6, 8'h00, 8'h00, 8'h00, "R2 code6 none");
    alu_step(3'd7, 8'h00, 8'h00, 8'h00, "R2 code7 none");
    alu_valid = 0; alu_op = 3'd4; alu_res = 8'h00; tick(); clear_in();
    chk("R2 invalid ignored", int'(flags), int'(exp_f));

    // R3/R4: logic and move keep half and carry
    for (int r = 0; r < 256; r++) begin
      alu_step(3'd1, 8'h0F, 8'hF1, 8'h00, "R3 setup");
      alu_step((r % 2 == 0) ? 3'd4 : 3'd5, 8'h00, 8'h00, 8'(r), "R2 R3 R4 logic/move");
    end

    // R2/R3/R4: every pair for plain add, grid for accumulator add
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        alu_step(3'd1, 8'(a), 8'(b), 8'(a + b), "R2 R3 R4 add");
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 3)
        alu_step(3'd3, 8'(a), 8'(b), 8'(a + b), "R3 R4 accadd");

    // R4: add-with-carry at both carry-in values
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        for (int c = 0; c < 2; c++) begin
          if (c == 1) alu_step(3'd1, 8'hFF, 8'h01, 8'h00, "R4 carry setup");
          else        alu_step(3'd1, 8'h00, 8'h00, 8'h00, "R4 carry setup");
          alu_step(3'd2, 8'(a), 8'(b), 8'(a + b + c), "R4 adc");
        end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule